// File: doc/BRIEF.md
# Add/Subtract ALU with Status Flags

This block is an N-bit arithmetic and logic unit (32 bits by default) with a registered set of four status flags: zero, negative, signed overflow and carry. Each cycle it takes two operands and a 3-bit operation code, and it produces a combinational result. When the flag write-enable is high, the flags are loaded on the next rising clock edge.

Subtraction has no adder of its own. The second operand is inverted and the carry-in is forced to one, so both add and subtract use one shared adder. Add-with-carry and subtract-with-borrow take the stored carry flag as the adder's carry-in. A wide value can therefore be added or subtracted one word at a time: issue ADD or SUB on the low word, then ADC or SBC on each higher word.

A parameter sets how the carry flag reads after a subtraction. The flag can mean "no borrow occurred" or "a borrow occurred". Subtract-with-borrow reads the stored flag using the same convention.

Top module: `alu_flags_core`

## Requirements
- R1: Operation code 0 (ADD) gives result = A + B modulo 2^WIDTH. The adder carry-in is 0, and the carry flag candidate is the carry out of the top bit.
- R2: Operation code 1 (SUB) gives result = A - B, computed as A + ~B + 1. With BORROW_STYLE = 0 the carry candidate is the raw carry out, so 1 means A >= B unsigned. With BORROW_STYLE = 1 the carry candidate is the inverse of the raw carry out.
- R3: The signed-overflow candidate for codes 0 to 3 is set exactly when the carry into the top bit differs from the carry out of it. That is the same as A and the effective B sharing a sign while the result's sign differs.
- R4: Operation code 2 (ADC) gives result = A + B + C, where C is the stored carry flag.
- R5: Operation code 3 (SBC) gives result = A + ~B + cin. The carry-in cin is the stored carry flag when BORROW_STYLE = 0 and its inverse when BORROW_STYLE = 1. The carry candidate uses the same convention as SUB.
- R6: Operation codes 4, 5 and 6 give the bitwise AND, OR and NOR of A and B.
- R7: Operation code 7 (SLT) gives 1 in bit 0 when A < B as signed numbers, and 0 otherwise. All upper bits are 0. SLT never changes the flags, even when the write-enable is high.
- R8: On every flag-updating operation, the zero flag is set exactly when the result is all zeros, and the negative flag copies the result's top bit.
- R9: Logic operations (codes 4 to 6) clear the overflow flag and leave the carry flag unchanged.
- R10: When the write-enable is low, all four flags keep their values.
- R11: After reset, all four flags are 0.
- R12: An ADD on the low words followed by an ADC on the high words gives the correct double-width sum. A SUB followed by an SBC gives the correct double-width difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (0 ADD, 1 SUB, 2 ADC, 3 SBC, 4 AND, 5 OR, 6 NOR, 7 SLT) |
| flag_we | input | 1 | Loads the flags at the next rising edge |
| result | output | WIDTH | Combinational result |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered signed-overflow flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The assertions assume that the operation code, operands and write-enable stay stable across each rising edge and are never unknown while reset is released. The bench meets this by changing every input only just after a falling edge. The assertions also assume the write-enable is low during reset, so the flag comparisons start from the reset values; the bench holds every input at zero until reset is released. The stimulus is chosen to reach carry out, borrow, signed overflow in both directions, and an all-zero result. It also includes SLT operand pairs whose subtraction overflows.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_ADC = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_NOR = 3'd6,
        OP_SLT = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } flag_s;

endpackage

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
    import alu_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit BORROW_STYLE = 1'b0
) (
    input  alu_op_e             op,
    input  logic [WIDTH-1:0]    b_in,
    input  logic                c_stored,
    output logic [WIDTH-1:0]    b_eff,
    output logic                carry_in,
    output logic                is_sub
);

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_SLT);
        b_eff    = is_sub ? ~b_in : b_in;
        unique case (op)
            OP_ADD:  carry_in = 1'b0;
            OP_ADC:  carry_in = c_stored;
            OP_SBC:  carry_in = c_stored ^ BORROW_STYLE;
            default: carry_in = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_top,
    output logic             c_out
);

    localparam int LOW_W = WIDTH - 1;

    logic [LOW_W:0] low_sum;
    logic [1:0]     top_sum;

    always_comb begin
        low_sum    = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        c_into_top = low_sum[LOW_W];
        top_sum    = {1'b0, a[WIDTH-1]} + {1'b0, b[WIDTH-1]} + {1'b0, c_into_top};
        sum        = {top_sum[0], low_sum[LOW_W-1:0]};
        c_out      = top_sum[1];
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = ~(a | b);
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  flag_s cand,
    output flag_s flags
);

    flag_s flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (upd) begin
            flags_d = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags_q))
        else $error("flags moved without update");

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flags_q == $past(cand))
        else $error("flags not loaded from candidate");

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
    import alu_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit BORROW_STYLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_c
);

    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic             carry_in;
    logic             is_sub;
    logic [WIDTH-1:0] sum;
    logic             c_into_top;
    logic             c_out;
    logic [WIDTH-1:0] logic_y;
    logic             is_arith;
    logic             is_logic;
    logic             v_arith;
    logic             c_arith;
    logic             upd;
    flag_s            cand;
    flag_s            flags;

    assign op = alu_op_e'(op_sel);

    alu_opnd_prep #(.WIDTH(WIDTH), .BORROW_STYLE(BORROW_STYLE)) u_prep (
        .op       (op),
        .b_in     (opnd_b),
        .c_stored (flags.c),
        .b_eff    (b_eff),
        .carry_in (carry_in),
        .is_sub   (is_sub)
    );

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .a          (opnd_a),
        .b          (b_eff),
        .cin        (carry_in),
        .sum        (sum),
        .c_into_top (c_into_top),
        .c_out      (c_out)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bit (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) || (op == OP_SBC);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_NOR);
        v_arith  = c_into_top ^ c_out;
        c_arith  = is_sub ? (c_out ^ BORROW_STYLE) : c_out;
        if (op == OP_SLT) begin
            result = {{(WIDTH-1){1'b0}}, sum[MSB] ^ v_arith};
        end else if (is_logic) begin
            result = logic_y;
        end else begin
            result = sum;
        end
        cand.z = (result == '0);
        cand.n = result[MSB];
        cand.v = is_logic ? 1'b0 : v_arith;
        cand.c = is_logic ? flags.c : c_arith;
        upd    = flag_we && (op != OP_SLT);
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .cand  (cand),
        .flags (flags)
    );

    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_v = flags.v;
    assign flag_c = flags.c;

    assert_ovf_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith && v_arith) |-> ((opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB])))
        else $error("overflow without sign mismatch");

    assert_slt_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SLT) |-> (result[MSB:1] == '0))
        else $error("slt upper bits nonzero");

    assert_slt_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SLT) |=> $stable({flag_z, flag_n, flag_v, flag_c}))
        else $error("slt changed flags");

    assert_logic_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && is_logic) |=> !flag_v)
        else $error("logic op left overflow set");

    assert_logic_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && is_logic) |=> (flag_c == $past(flag_c)))
        else $error("logic op changed carry");

endmodule

// File: tb/sim_alu_flags_core.sv
module sim_alu_flags_core;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'd0;
    logic         we = 1'b0;
    logic [W-1:0] result;
    logic         fz, fn, fv, fc;

    int total = 0;
    int bad = 0;

    logic m_z = 1'b0, m_n = 1'b0, m_v = 1'b0, m_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_core #(.WIDTH(W), .BORROW_STYLE(1'b0)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .opnd_a  (a),
        .opnd_b  (b),
        .op_sel  (op),
        .flag_we (we),
        .result  (result),
        .flag_z  (fz),
        .flag_n  (fn),
        .flag_v  (fv),
        .flag_c  (fc)
    );

    task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [W-1:0] ai, input logic [W-1:0] bi,
                          input logic [2:0] opi, input logic wei, output logic [W-1:0] r_out);
        logic [W-1:0] bb, r;
        logic [W:0]   s;
        logic         ci, ez, en, ev, ec, up;
        @(negedge clk);
        a = ai; b = bi; op = opi; we = wei;
        bb = (opi == 3'd1 || opi == 3'd3 || opi == 3'd7) ? ~bi : bi;
        case (opi)
            3'd0:    ci = 1'b0;
            3'd2:    ci = m_c;
            3'd3:    ci = m_c;
            default: ci = 1'b1;
        endcase
        s  = {1'b0, ai} + {1'b0, bb} + {{W{1'b0}}, ci};
        ev = (ai[W-1] == bb[W-1]) && (s[W-1] != ai[W-1]);
        ec = s[W];
        up = wei;
        case (opi)
            3'd4: r = ai & bi;
            3'd5: r = ai | bi;
            3'd6: r = ~(ai | bi);
            3'd7: begin
                r  = {{(W-1){1'b0}}, s[W-1] ^ ev};
                up = 1'b0;
            end
            default: r = s[W-1:0];
        endcase
        if (opi >= 3'd4 && opi <= 3'd6) begin
            ev = 1'b0;
            ec = m_c;
        end
        ez = (r == '0);
        en = r[W-1];
        #1;
        check_val({tag, " result"}, result, r);
        r_out = result;
        if (up) begin
            m_z = ez; m_n = en; m_v = ev; m_c = ec;
        end
        @(negedge clk);
        check_val({tag, " flags zncv"}, {28'd0, fz, fn, fv, fc}, {28'd0, m_z, m_n, m_v, m_c});
        we = 1'b0;
    endtask

    task automatic t_reset();
        check_val("R11 reset flags", {28'd0, fz, fn, fv, fc}, '0);
    endtask

    task automatic t_add();
        logic [W-1:0] r;
        run_op("R1 add small", 32'd5, 32'd2, 3'd0, 1'b1, r);
        check_val("R1 5+2", r, 32'd7);
        run_op("R1 R8 add wrap", 32'hFFFF_FFFF, 32'd1, 3'd0, 1'b1, r);
        check_val("R8 zero carry", {30'd0, fz, fc}, {30'd0, 1'b1, 1'b1});
        run_op("R3 add ovf", 32'h7FFF_FFFF, 32'd1, 3'd0, 1'b1, r);
        check_val("R3 pos overflow nv", {30'd0, fn, fv}, 32'd3);
        run_op("R3 add neg ovf", 32'h8000_0000, 32'h8000_0000, 3'd0, 1'b1, r);
        check_val("R3 neg overflow vc", {30'd0, fv, fc}, 32'd3);
    endtask

    task automatic t_sub();
        logic [W-1:0] r;
        run_op("R2 sub nb", 32'd5, 32'd2, 3'd1, 1'b1, r);
        check_val("R2 5-2 carry", {31'd0, fc}, 32'd1);
        run_op("R2 sub borrow", 32'd2, 32'd5, 3'd1, 1'b1, r);
        check_val("R2 2-5 value", r, 32'hFFFF_FFFD);
        check_val("R2 borrow carry0", {31'd0, fc}, 32'd0);
        run_op("R3 sub ovf", 32'h8000_0000, 32'd1, 3'd1, 1'b1, r);
        check_val("R3 sub overflow", {31'd0, fv}, 32'd1);
        run_op("R8 sub equal", 32'h1234_5678, 32'h1234_5678, 3'd1, 1'b1, r);
        check_val("R8 equal zero", {31'd0, fz}, 32'd1);
    endtask

    task automatic t_chain();
        logic [W-1:0] lo, hi;
        run_op("R12 add low", 32'hFFFF_FFFF, 32'd1, 3'd0, 1'b1, lo);
        run_op("R4 adc high", 32'd1, 32'd0, 3'd2, 1'b1, hi);
        check_val("R12 wide sum", {hi[15:0], lo[15:0]}, 32'h0002_0000);
        run_op("R12 sub low", 32'd0, 32'd1, 3'd1, 1'b1, lo);
        run_op("R5 sbc high", 32'd1, 32'd0, 3'd3, 1'b1, hi);
        check_val("R12 wide diff hi", hi, 32'd0);
        check_val("R12 wide diff lo", lo, 32'hFFFF_FFFF);
        run_op("R5 sbc no borrow", 32'd9, 32'd4, 3'd3, 1'b1, hi);
        check_val("R5 9-4 with carry set", hi, 32'd5);
    endtask

    task automatic t_logic();
        logic [W-1:0] r;
        run_op("R9 set carry", 32'hFFFF_FFFF, 32'h8000_0000, 3'd0, 1'b1, r);
        run_op("R6 and", 32'hF0F0_1234, 32'h0FF0_FF00, 3'd4, 1'b1, r);
        check_val("R6 and value", r, 32'h00F0_1200);
        check_val("R9 and v0 c1", {30'd0, fv, fc}, 32'd1);
        run_op("R6 or", 32'hF000_0000, 32'h0000_000F, 3'd5, 1'b1, r);
        check_val("R6 or value", r, 32'hF000_000F);
        run_op("R6 nor", 32'hFFFF_0000, 32'h0000_FFFF, 3'd6, 1'b1, r);
        check_val("R6 nor zero", {31'd0, fz}, 32'd1);
    endtask

    task automatic t_slt();
        logic [W-1:0] r;
        run_op("R7 set flags", 32'd0, 32'd0, 3'd1, 1'b1, r);
        run_op("R7 slt neg", 32'hFFFF_FFFF, 32'd1, 3'd7, 1'b1, r);
        check_val("R7 -1<1", r, 32'd1);
        run_op("R7 slt pos", 32'd1, 32'hFFFF_FFFF, 3'd7, 1'b1, r);
        check_val("R7 1<-1", r, 32'd0);
        run_op("R7 slt ovf", 32'h8000_0000, 32'h7FFF_FFFF, 3'd7, 1'b1, r);
        check_val("R7 min<max", r, 32'd1);
        check_val("R7 flags untouched", {28'd0, fz, fn, fv, fc}, {28'd0, 4'b1001});
    endtask

    task automatic t_hold();
        logic [W-1:0] r;
        run_op("R10 base", 32'd3, 32'd3, 3'd1, 1'b1, r);
        run_op("R10 no we", 32'h7FFF_FFFF, 32'd1, 3'd0, 1'b0, r);
        check_val("R10 held", {28'd0, fz, fn, fv, fc}, {28'd0, 4'b1001});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_chain();
        t_logic();
        t_slt();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule